// File: doc/BRIEF.md
# Dual Current Fault Detector

This block watches two averaged current magnitudes, one from the phase conductor and one from the neutral return, and picks the one used for billing. A downstream energy path reads the selected magnitude. When the two currents disagree by more than one eighth of the billing channel, the block raises a fault flag. It still bills on the larger current during a fault, but it swaps channels only when the other side is clearly larger. The fault flag is independent of any pulse or energy output further down the chain.

Magnitude words arrive already rectified and averaged, together with a valid strobe. A slow `tick` input marks the passage of time. Both the fault flag and a channel swap must hold continuously for a programmable number of ticks before they take effect: one second for the flag and 1.2 seconds for the swap. Below 0.5% of full scale the detector stays silent, so noise at light load cannot trip it. All threshold tests are integer multiplies and shifts, with no divider.

Top module: `dcfd_fault_monitor`

## Requirements
- R1: After reset, channel A is active (`sel_b`=0), `fault`=0 and `sel_mag`=0.
- R2: A pair of words is captured only on a cycle with `mag_valid`=1. `sel_mag` shows the captured word of the active channel from the next clock edge. Input changes without `mag_valid` have no effect on any output.
- R3: A mismatch exists when |A-B| > floor(active/8), where active is the captured word of the billing channel.
- R4: `fault` rises only at the tick on which a mismatch has held for FAULT_TICKS (= SEC_TICKS) consecutive ticks. If the mismatch lapses, the count restarts from zero.
- R5: `fault` falls at the first clock edge on which no mismatch exists, whichever channel is active.
- R6: The billing channel toggles (`sel_b`: 0 = A, 1 = B) at the tick on which 50*other > 57*active has held for SWAP_TICKS = round(1.2*SEC_TICKS) consecutive ticks. `sel_mag` follows at the same edge.
- R7: After a swap, the channel does not swap back until the original channel exceeds 114% of the now active channel for SWAP_TICKS ticks.
- R8: If the inactive channel is more than 12.5% below the active one, `fault` asserts but no swap ever happens.
- R9: While 200*active < `full_scale`, no fault or swap is qualified, and an asserted `fault` clears.
- R10: Equality at either threshold does not count: |A-B| = floor(active/8) gives no fault, and 50*other = 57*active gives no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mag_a | input | MAG_W | Averaged magnitude, channel A (phase) |
| mag_b | input | MAG_W | Averaged magnitude, channel B (neutral) |
| mag_valid | input | 1 | Capture strobe for mag_a and mag_b |
| full_scale | input | MAG_W | Full-scale magnitude used for the light-load gate |
| tick | input | 1 | Time-base pulse, one per qualification step |
| sel_b | output | 1 | Active billing channel, 0 = A, 1 = B |
| fault | output | 1 | Current mismatch flag |
| sel_mag | output | MAG_W | Captured magnitude of the active channel |

## Verification
The bench builds the block with MAG_W = 16 and SEC_TICKS = 10, so the flag qualifies after 10 ticks and a swap after 12. This puts the tick boundaries of R4, R6 and R7, including a lapse and restart, within a few hundred cycles. With a full scale of 40000, the light-load gate sits at an active magnitude of 200. That lets the bench place words exactly on the 12.5%, 114% and 0.5% limits and one step past them.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/dcfd_compare.sv
// Threshold tests between the active and the other channel, division free.
module dcfd_compare #(
  parameter int MAG_W = 16
) (
  input  logic [MAG_W-1:0] act_mag,
  input  logic [MAG_W-1:0] oth_mag,
  input  logic [MAG_W-1:0] full_scale,
  output logic             detect_on,
  output logic             mismatch,
  output logic             overtake
);
  localparam int PW = MAG_W + 8;

  logic [PW-1:0]    act_x200, act_x57, oth_x50;
  logic [MAG_W-1:0] gap;

  always_comb begin
    act_x200  = PW'(act_mag) * PW'(200);
    act_x57   = PW'(act_mag) * PW'(57);
    oth_x50   = PW'(oth_mag) * PW'(50);
    gap       = (act_mag >= oth_mag) ? (act_mag - oth_mag) : (oth_mag - act_mag);
    detect_on = act_x200 >= PW'(full_scale);
    mismatch  = detect_on && (gap > (act_mag >> 3));
    overtake  = detect_on && (oth_x50 > act_x57);
  end
endmodule

// File: rtl/dcfd_qualify.sv
// Counts ticks while a condition holds without a break; fires on the last one.
module dcfd_qualify #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic tick,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt;

  assign hit = cond && tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dcfd_fault_monitor.sv
module dcfd_fault_monitor
  import dcfd_pkg::*;
#(
  parameter int MAG_W     = 16,
  parameter int SEC_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             mag_valid,
  input  logic [MAG_W-1:0] full_scale,
  input  logic             tick,
  output logic             sel_b,
  output logic             fault,
  output logic [MAG_W-1:0] sel_mag
);
  localparam int FAULT_TICKS = SEC_TICKS;
  localparam int SWAP_RAW    = (SEC_TICKS * 6 + 2) / 5;
  localparam int SWAP_TICKS  = (SWAP_RAW < 1) ? 1 : SWAP_RAW;

  logic [MAG_W-1:0] hold_a, hold_b, nxt_a, nxt_b;
  logic [MAG_W-1:0] act_mag, oth_mag;
  chan_e            active, nxt_active;
  logic             detect_on, mismatch, overtake;
  logic [1:0]       q_cond, q_hit;
  logic             fault_hit, swap_hit;

  always_comb begin
    act_mag = (active == CH_B) ? hold_b : hold_a;
    oth_mag = (active == CH_B) ? hold_a : hold_b;
  end

  dcfd_compare #(.MAG_W(MAG_W)) u_cmp (
    .act_mag   (act_mag),
    .oth_mag   (oth_mag),
    .full_scale(full_scale),
    .detect_on (detect_on),
    .mismatch  (mismatch),
    .overtake  (overtake)
  );

  assign q_cond = {overtake, mismatch};

  // Index 0 qualifies the fault flag, index 1 qualifies a channel swap.
  for (genvar gi = 0; gi < 2; gi++) begin : g_qual
    localparam int LIM = (gi == 0) ? FAULT_TICKS : SWAP_TICKS;
    dcfd_qualify #(.LIMIT(LIM)) u_q (
      .clk (clk),
      .rst (rst),
      .cond(q_cond[gi]),
      .tick(tick),
      .hit (q_hit[gi])
    );
  end

  assign fault_hit = q_hit[0];
  assign swap_hit  = q_hit[1];

  always_comb begin
    nxt_a      = mag_valid ? mag_a : hold_a;
    nxt_b      = mag_valid ? mag_b : hold_b;
    nxt_active = active;
    if (swap_hit) nxt_active = (active == CH_A) ? CH_B : CH_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a  <= '0;
      hold_b  <= '0;
      active  <= CH_A;
      fault   <= 1'b0;
      sel_mag <= '0;
    end else begin
      hold_a  <= nxt_a;
      hold_b  <= nxt_b;
      active  <= nxt_active;
      sel_mag <= (nxt_active == CH_B) ? nxt_b : nxt_a;
      if (!mismatch)      fault <= 1'b0;
      else if (fault_hit) fault <= 1'b1;
    end
  end

  assign sel_b = (active == CH_B);

  AST_FAULT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(fault_hit)); // R4
  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (fault && !mismatch) |=> !fault); // R5
  AST_SWAP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_b) |-> $past(swap_hit)); // R6
  AST_LIGHT_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !detect_on |=> !fault); // R9
  AST_LIGHT_LOAD_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
    !detect_on |=> $stable(sel_b)); // R9
endmodule

// File: tb/dcfd_fault_monitor_test.sv
module dcfd_fault_monitor_test;
  localparam int MAG_W = 16;
  localparam int SEC   = 10;
  localparam int FT    = 10;
  localparam int ST    = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [MAG_W-1:0] mag_a = '0, mag_b = '0, full_scale = 16'd40000;
  logic             mag_valid = 1'b0, tick = 1'b0;
  logic             sel_b, fault;
  logic [MAG_W-1:0] sel_mag;
  int               n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dcfd_fault_monitor #(.MAG_W(MAG_W), .SEC_TICKS(SEC)) uut (
    .clk(clk), .rst(rst), .mag_a(mag_a), .mag_b(mag_b), .mag_valid(mag_valid),
    .full_scale(full_scale), .tick(tick), .sel_b(sel_b), .fault(fault), .sel_mag(sel_mag)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mag_valid = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mags(input int a, input int b);
    mag_a = MAG_W'(a); mag_b = MAG_W'(b); mag_valid = 1'b1;
    @(negedge clk);
    mag_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(sel_b, 0, "R1", "sel_b after reset");
    check(fault, 0, "R1", "fault after reset");
    check(sel_mag, 0, "R1", "sel_mag after reset");
  endtask

  task automatic t_capture();
    do_reset();
    mag_a = 16'd1000; mag_b = 16'd1000; mag_valid = 1'b1;
    @(negedge clk);
    mag_valid = 1'b0;
    check(sel_mag, 1000, "R2", "sel_mag one edge after strobe");
    mag_a = 16'd3000; mag_b = 16'd100;
    repeat (3) @(negedge clk);
    ticks(FT + 2);
    check(sel_mag, 1000, "R2", "sel_mag with unstrobed change");
    check(fault, 0, "R2", "fault with unstrobed change");
  endtask

  task automatic t_low_side();
    do_reset();
    set_mags(1000, 800);
    ticks(FT - 1);
    check(fault, 0, "R4", "fault one tick early");
    ticks(1);
    check(fault, 1, "R8", "fault with low inactive side");
    ticks(ST + 5);
    check(sel_b, 0, "R8", "no swap with low inactive side");
    check(sel_mag, 1000, "R8", "billing stays on A");
    set_mags(1000, 1000);
    check(fault, 0, "R5", "fault release");
  endtask

  task automatic t_lapse();
    do_reset();
    set_mags(1000, 800);
    ticks(6);
    set_mags(1000, 1000);
    set_mags(1000, 800);
    ticks(FT - 1);
    check(fault, 0, "R4", "count restarted after lapse");
    ticks(1);
    check(fault, 1, "R4", "fault after full run");
  endtask

  task automatic t_bounds();
    do_reset();
    set_mags(1000, 875);
    ticks(2 * FT);
    check(fault, 0, "R10", "gap equal to active/8");
    set_mags(1000, 874);
    ticks(FT);
    check(fault, 1, "R3", "gap one above active/8");
    do_reset();
    set_mags(1000, 1140);
    ticks(2 * ST);
    check(sel_b, 0, "R10", "other at exactly 114%");
    set_mags(1000, 1141);
    ticks(ST);
    check(sel_b, 1, "R6", "other just past 114%");
  endtask

  task automatic t_swap();
    do_reset();
    set_mags(1000, 1500);
    ticks(FT);
    check(fault, 1, "R4", "fault during overtake");
    ticks(ST - FT - 1);
    check(sel_b, 0, "R6", "no swap one tick early");
    ticks(1);
    check(sel_b, 1, "R6", "swap to B");
    check(sel_mag, 1500, "R6", "sel_mag follows swap");
    check(fault, 1, "R6", "fault held after swap");
    set_mags(1100, 1000);
    check(fault, 0, "R5", "release with B active");
    ticks(2 * ST);
    check(sel_b, 1, "R7", "no swap back at 110%");
    set_mags(1200, 1000);
    ticks(ST - 1);
    check(sel_b, 1, "R7", "swap back one tick early");
    ticks(1);
    check(sel_b, 0, "R7", "swap back to A");
    check(sel_mag, 1200, "R7", "sel_mag after swap back");
  endtask

  task automatic t_light_load();
    do_reset();
    set_mags(150, 50);
    ticks(2 * FT);
    check(fault, 0, "R9", "no fault below gate");
    set_mags(150, 300);
    ticks(2 * ST);
    check(sel_b, 0, "R9", "no swap below gate");
    set_mags(200, 100);
    ticks(FT);
    check(fault, 1, "R9", "fault at gate edge");
    set_mags(100, 10);
    check(fault, 0, "R9", "fault cleared by light load");
  endtask

  initial begin
    t_reset();
    t_capture();
    t_low_side();
    t_lapse();
    t_bounds();
    t_swap();
    t_light_load();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule